// File: doc/BRIEF.md
# Quadrature Position Counter with Index Reload

This block keeps a 32-bit position for an incremental encoder. It takes the encoder's two phase lines A and B, the once-per-revolution index line Z and an optional origin switch line. It runs entirely on the system clock. Every input first passes through a synchroniser. Edges are then detected by comparing each sample with the previous one.

Four counting modes are available. In the clockwise/counter-clockwise mode, A and B carry separate up and down pulse trains. In the three quadrature modes, the count advances once per cycle, twice per cycle or four times per cycle. Software picks one of the four {A,B} states. While Z is high in that state, and also the origin line when origin qualification is on, the counter loads a programmable value. A strobe marks each cycle in which that load happens.

A sample in which both phases change at once cannot occur in a valid quadrature sequence. In the quadrature modes such a sample moves nothing and sets a sticky error flag.

Top module: `qenc_position_counter`

## Requirements
- R1: While rst_n is low at a clock edge, pos_count becomes 0 and reload_evt and seq_error become 0. Reset is synchronous.
- R2: With cfg_mode=2'b00 (pulse mode), a rising edge on A adds 1 and a rising edge on B subtracts 1. If both rise in the same sample, the count does not change. Falling edges do nothing, and seq_error is never set in this mode.
- R3: With cfg_mode=2'b01 (single-edge quadrature), the count changes only when A changes while B is low. A rising adds 1 and A falling subtracts 1, so one full cycle moves the count by exactly one.
- R4: With cfg_mode=2'b10 (double-edge quadrature), every change of A alone moves the count. The count goes up when the new A differs from B, and down otherwise. A change of B alone does nothing.
- R5: With cfg_mode=2'b11 (four-edge quadrature), every change of exactly one phase moves the count by one. The count goes up for the sequence {A,B} 00,10,11,01 and down for the reverse sequence.
- R6: In any quadrature mode, a sample in which A and B both change leaves the count unchanged and sets seq_error. Only reset clears seq_error.
- R7: The count wraps modulo 2^32 in both directions: 0 minus 1 gives 0xFFFFFFFF, and 0xFFFFFFFF plus 1 gives 0.
- R8: While Z is high and {A,B} equals cfg_phase_sel (A is the upper bit), the count loads cfg_reload. While Z is low, or while the phases are in any other state, no load takes place.
- R9: With cfg_org_en=1, a load also needs the origin input to be high. With cfg_org_en=0, the origin input is ignored.
- R10: A load takes priority over a count step in the same cycle. reload_evt is high in exactly the cycles that follow a clock edge at which the load took place.
- R11: A change on an input pin shows on pos_count and reload_evt after the third rising clock edge that follows it (two synchroniser stages plus the count register), and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enc_a | input | 1 | Phase A, or up pulses in pulse mode |
| enc_b | input | 1 | Phase B, or down pulses in pulse mode |
| enc_z | input | 1 | Index line |
| enc_org | input | 1 | Origin switch line |
| cfg_mode | input | 2 | 00 pulse, 01 single-edge, 10 double-edge, 11 four-edge |
| cfg_org_en | input | 1 | Also require the origin line for a load |
| cfg_phase_sel | input | 2 | {A,B} state in which a load may happen |
| cfg_reload | input | 32 | Value loaded into the count |
| pos_count | output | 32 | Current position |
| reload_evt | output | 1 | High for one cycle per load |
| seq_error | output | 1 | Sticky flag for a sample with both phases changed |

## Verification
The bench walks each quadrature mode forward and backward through complete cycles. A design that took the direction from the wrong phase would count backward. A design that counted the wrong edges would reach the wrong total, for example an X1 counter that also fires on the falling edge of A while B is high.

It sets Z high with the phases outside the selected state, to catch a load that ignores the phase. It also sets Z high in the same sample as a count step, which exposes a count that wins over the load, and it holds the origin line low while origin qualification is on.

Further cases cover both directions across the wrap point and simultaneous pulses in pulse mode. A sample in which both phases flip must leave the count alone. The exact cycle of an update is checked, which catches a missing or extra pipeline stage.

// File: rtl/qenc_pkg.sv
// qenc_pkg: shared types and widths for the quadrature position counter.
// Assumes: nothing beyond IEEE 1800-2017.
package qenc_pkg;

    localparam int unsigned CNT_W = 32;

    // Counting mode, encoded as the cfg_mode port.
    typedef enum logic [1:0] {
        MODE_PULSE = 2'b00,
        MODE_X1    = 2'b01,
        MODE_X2    = 2'b10,
        MODE_X4    = 2'b11
    } mode_e;

endpackage

// File: rtl/qenc_sync.sv
// qenc_sync: multi-stage synchroniser for a bundle of asynchronous lines.
// Assumes: the lines are independent; each one settles within one clock
// per stage. After reset every stage holds zero.
module qenc_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw pins.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[s] <= '0;
                    else        stg[s] <= d;
                end
            end else begin : g_next
                // Shift the bundle one stage further.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[s] <= '0;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/qenc_step_decode.sv
// qenc_step_decode: turns synchronised A/B samples into up/down step
// requests for the selected mode and flags illegal double transitions.
// Assumes: a_s/b_s are already synchronous to clk. At most one of
// inc/dec is high in any cycle.
module qenc_step_decode
    import qenc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mode_e mode,
    input  logic  a_s,
    input  logic  b_s,
    output logic  inc,
    output logic  dec,
    output logic  err_flag
);

    logic a_q, b_q;
    logic a_chg, b_chg, both_chg, up_dir, quad_step, is_quad;

    // Hold the previous sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= 1'b0;
            b_q <= 1'b0;
        end else begin
            a_q <= a_s;
            b_q <= b_s;
        end
    end

    assign a_chg    = a_s ^ a_q;
    assign b_chg    = b_s ^ b_q;
    assign both_chg = a_chg & b_chg;
    assign up_dir   = a_s ^ b_q;
    assign is_quad  = (mode != MODE_PULSE);

    // Decide whether this sample is a counted edge in the quadrature modes.
    always_comb begin
        unique case (mode)
            MODE_X1: quad_step = a_chg & ~b_chg & ~b_q;
            MODE_X2: quad_step = a_chg & ~b_chg;
            MODE_X4: quad_step = a_chg ^ b_chg;
            default: quad_step = 1'b0;
        endcase
    end

    // Map the mode onto the up and down requests.
    always_comb begin
        if (mode == MODE_PULSE) begin
            inc = a_chg & a_s & ~(b_chg & b_s);
            dec = b_chg & b_s & ~(a_chg & a_s);
        end else begin
            inc = quad_step & up_dir;
            dec = quad_step & ~up_dir;
        end
    end

    // Sticky flag for a sample with both phases changed.
    always_ff @(posedge clk) begin
        if (!rst_n)                     err_flag <= 1'b0;
        else if (is_quad && both_chg)   err_flag <= 1'b1;
    end

    assert_one_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({inc, dec}));

    assert_illegal_still_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_quad && a_chg && b_chg) |-> (!inc && !dec));

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

endmodule

// File: rtl/qenc_counter.sv
// qenc_counter: position register with index-qualified reload.
// Assumes: inc and dec are never both high. The reload request is
// evaluated on synchronised pins and takes priority over any step.
module qenc_counter #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         dec,
    input  logic         a_s,
    input  logic         b_s,
    input  logic         z_s,
    input  logic         org_s,
    input  logic         org_en,
    input  logic [1:0]   phase_sel,
    input  logic [W-1:0] rld_value,
    output logic [W-1:0] count_q,
    output logic         evt_q
);

    logic hit;

    // Reload qualifier: index high, origin if enabled, phase state matches.
    assign hit = z_s && (org_s || !org_en) && ({a_s, b_s} == phase_sel);

    // Position register: reload beats a step; wraps modulo 2^W.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            evt_q   <= 1'b0;
        end else begin
            evt_q <= hit;
            if (hit)      count_q <= rld_value;
            else if (inc) count_q <= count_q + 1'b1;
            else if (dec) count_q <= count_q - 1'b1;
        end
    end

    assert_reload_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (count_q == $past(rld_value) && evt_q));

    assert_step_wraps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && inc) |=> (count_q == $past(count_q) + 1'b1));

    assert_step_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && dec) |=> (count_q == $past(count_q) - 1'b1));

    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && !inc && !dec) |=> ($stable(count_q) && !evt_q));

endmodule

// File: rtl/qenc_position_counter.sv
// qenc_position_counter: top of the encoder position counter. Synchronises
// the four encoder lines, decodes steps for the selected mode and keeps
// the position with an index-qualified reload.
// Assumes: configuration inputs are quasi-static and synchronous to clk.
module qenc_position_counter
    import qenc_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enc_a,
    input  logic             enc_b,
    input  logic             enc_z,
    input  logic             enc_org,
    input  logic [1:0]       cfg_mode,
    input  logic             cfg_org_en,
    input  logic [1:0]       cfg_phase_sel,
    input  logic [CNT_W-1:0] cfg_reload,
    output logic [CNT_W-1:0] pos_count,
    output logic             reload_evt,
    output logic             seq_error
);

    localparam int unsigned NLINES = 4;

    logic [NLINES-1:0] pins_s;
    logic              inc, dec;
    mode_e             mode;

    assign mode = mode_e'(cfg_mode);

    qenc_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({enc_a, enc_b, enc_z, enc_org}),
        .q     (pins_s)
    );

    qenc_step_decode u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .a_s      (pins_s[3]),
        .b_s      (pins_s[2]),
        .inc      (inc),
        .dec      (dec),
        .err_flag (seq_error)
    );

    qenc_counter #(.W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc       (inc),
        .dec       (dec),
        .a_s       (pins_s[3]),
        .b_s       (pins_s[2]),
        .z_s       (pins_s[1]),
        .org_s     (pins_s[0]),
        .org_en    (cfg_org_en),
        .phase_sel (cfg_phase_sel),
        .rld_value (cfg_reload),
        .count_q   (pos_count),
        .evt_q     (reload_evt)
    );

endmodule

// File: tb/sim_qenc_position_counter.sv
// Bench for qenc_position_counter: vector table walk, then directed cases.
module sim_qenc_position_counter;

    localparam logic [31:0] RLD = 32'h1000_0000;
    localparam int NV = 47;

    // Vector fields: mode, org_en, phase_sel, {a,b,z,org}, count, evt, err.
    localparam logic [42:0] VEC [NV] = '{
        // R5: four-edge mode, forward and back, then wrap below zero (R7)
        {2'd3,1'b0,2'b00,4'b1000,32'd1,1'b0,1'b0},
        {2'd3,1'b0,2'b00,4'b1100,32'd2,1'b0,1'b0},
        {2'd3,1'b0,2'b00,4'b0100,32'd3,1'b0,1'b0},
        {2'd3,1'b0,2'b00,4'b0000,32'd4,1'b0,1'b0},
        {2'd3,1'b0,2'b00,4'b0100,32'd3,1'b0,1'b0},
        {2'd3,1'b0,2'b00,4'b1100,32'd2,1'b0,1'b0},
        {2'd3,1'b0,2'b00,4'b1000,32'd1,1'b0,1'b0},
        {2'd3,1'b0,2'b00,4'b0000,32'd0,1'b0,1'b0},
        {2'd3,1'b0,2'b00,4'b0100,32'hFFFF_FFFF,1'b0,1'b0},
        {2'd3,1'b0,2'b00,4'b0000,32'd0,1'b0,1'b0},
        // R4: double-edge mode
        {2'd2,1'b0,2'b00,4'b1000,32'd1,1'b0,1'b0},
        {2'd2,1'b0,2'b00,4'b1100,32'd1,1'b0,1'b0},
        {2'd2,1'b0,2'b00,4'b0100,32'd2,1'b0,1'b0},
        {2'd2,1'b0,2'b00,4'b0000,32'd2,1'b0,1'b0},
        {2'd2,1'b0,2'b00,4'b0100,32'd2,1'b0,1'b0},
        {2'd2,1'b0,2'b00,4'b1100,32'd1,1'b0,1'b0},
        {2'd2,1'b0,2'b00,4'b1000,32'd1,1'b0,1'b0},
        {2'd2,1'b0,2'b00,4'b0000,32'd0,1'b0,1'b0},
        // R3: single-edge mode
        {2'd1,1'b0,2'b00,4'b1000,32'd1,1'b0,1'b0},
        {2'd1,1'b0,2'b00,4'b1100,32'd1,1'b0,1'b0},
        {2'd1,1'b0,2'b00,4'b0100,32'd1,1'b0,1'b0},
        {2'd1,1'b0,2'b00,4'b0000,32'd1,1'b0,1'b0},
        {2'd1,1'b0,2'b00,4'b0100,32'd1,1'b0,1'b0},
        {2'd1,1'b0,2'b00,4'b1100,32'd1,1'b0,1'b0},
        {2'd1,1'b0,2'b00,4'b1000,32'd1,1'b0,1'b0},
        {2'd1,1'b0,2'b00,4'b0000,32'd0,1'b0,1'b0},
        {2'd1,1'b0,2'b00,4'b0100,32'd0,1'b0,1'b0},
        {2'd1,1'b0,2'b00,4'b1100,32'd0,1'b0,1'b0},
        {2'd1,1'b0,2'b00,4'b1000,32'd0,1'b0,1'b0},
        {2'd1,1'b0,2'b00,4'b0000,32'hFFFF_FFFF,1'b0,1'b0},
        {2'd1,1'b0,2'b00,4'b1000,32'd0,1'b0,1'b0},
        {2'd1,1'b0,2'b00,4'b0000,32'hFFFF_FFFF,1'b0,1'b0},
        // R2: pulse mode
        {2'd0,1'b0,2'b00,4'b1000,32'd0,1'b0,1'b0},
        {2'd0,1'b0,2'b00,4'b0000,32'd0,1'b0,1'b0},
        {2'd0,1'b0,2'b00,4'b1000,32'd1,1'b0,1'b0},
        {2'd0,1'b0,2'b00,4'b0000,32'd1,1'b0,1'b0},
        {2'd0,1'b0,2'b00,4'b0100,32'd0,1'b0,1'b0},
        {2'd0,1'b0,2'b00,4'b0000,32'd0,1'b0,1'b0},
        {2'd0,1'b0,2'b00,4'b1100,32'd0,1'b0,1'b0},
        {2'd0,1'b0,2'b00,4'b0000,32'd0,1'b0,1'b0},
        // R8 wrong phase, R10 reload beats step, R9 origin qualification
        {2'd3,1'b0,2'b10,4'b0010,32'd0,1'b0,1'b0},
        {2'd3,1'b0,2'b10,4'b1010,RLD,1'b1,1'b0},
        {2'd3,1'b0,2'b10,4'b1100,RLD+32'd1,1'b0,1'b0},
        {2'd3,1'b1,2'b11,4'b1110,RLD+32'd1,1'b0,1'b0},
        {2'd3,1'b1,2'b11,4'b1111,RLD,1'b1,1'b0},
        {2'd3,1'b1,2'b11,4'b1100,RLD,1'b0,1'b0},
        // R6: both phases flip
        {2'd3,1'b0,2'b00,4'b0000,RLD,1'b0,1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enc_a = 1'b0, enc_b = 1'b0, enc_z = 1'b0, enc_org = 1'b0;
    logic [1:0]  cfg_mode = 2'd3;
    logic        cfg_org_en = 1'b0;
    logic [1:0]  cfg_phase_sel = 2'b00;
    logic [31:0] cfg_reload = RLD;
    logic [31:0] pos_count;
    logic        reload_evt, seq_error;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    qenc_position_counter u0 (
        .clk(clk), .rst_n(rst_n),
        .enc_a(enc_a), .enc_b(enc_b), .enc_z(enc_z), .enc_org(enc_org),
        .cfg_mode(cfg_mode), .cfg_org_en(cfg_org_en),
        .cfg_phase_sel(cfg_phase_sel), .cfg_reload(cfg_reload),
        .pos_count(pos_count), .reload_evt(reload_evt), .seq_error(seq_error)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        {enc_a, enc_b, enc_z, enc_org} = 4'b0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 count", pos_count, 32'd0);
        chk("R1 evt", {31'd0, reload_evt}, 32'd0);
        chk("R1 err", {31'd0, seq_error}, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            cfg_mode      = VEC[i][42:41];
            cfg_org_en    = VEC[i][40];
            cfg_phase_sel = VEC[i][39:38];
            {enc_a, enc_b, enc_z, enc_org} = VEC[i][37:34];
            repeat (4) @(negedge clk);
            chk($sformatf("vec %0d count (R2-R10 table)", i), pos_count, VEC[i][33:2]);
            chk($sformatf("vec %0d evt R10", i), {31'd0, reload_evt}, {31'd0, VEC[i][1]});
            chk($sformatf("vec %0d err R6", i), {31'd0, seq_error}, {31'd0, VEC[i][0]});
        end

        // R1 and R6: reset clears count and sticky error
        do_reset();
        chk("R1 count after reset", pos_count, 32'd0);
        chk("R6 err cleared by reset", {31'd0, seq_error}, 32'd0);

        // R7: wrap upward from all ones, loaded through reload (R10)
        cfg_mode = 2'd3; cfg_org_en = 1'b0; cfg_phase_sel = 2'b10;
        cfg_reload = 32'hFFFF_FFFF;
        @(negedge clk);
        {enc_a, enc_b, enc_z, enc_org} = 4'b1010;
        repeat (4) @(negedge clk);
        chk("R10 load all ones", pos_count, 32'hFFFF_FFFF);
        @(negedge clk);
        {enc_a, enc_b, enc_z, enc_org} = 4'b1100;
        repeat (4) @(negedge clk);
        chk("R7 wrap up to zero", pos_count, 32'd0);

        // R11: update lands on the third edge after the pin change
        {enc_a, enc_b, enc_z, enc_org} = 4'b0100;
        repeat (2) @(negedge clk);
        chk("R11 unchanged after two edges", pos_count, 32'd0);
        @(negedge clk);
        chk("R11 changed after third edge", pos_count, 32'd1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule